// File: doc/BRIEF.md
# Staged Calibration Bank Access Bridge

This block gives a host a narrow window onto a private bank of calibration registers that sit behind a delay-line controller. The host does not address the bank directly. It loads a command register with a 6-bit private address and a direction bit, loads a write-data register when it is writing, and then toggles a start bit. On the rising edge of that start bit the bridge runs one access to the private bank. A read leaves its result in a read-data register, where the host can fetch it.

The private bank is modelled in the block. It holds a write-protect gate that opens only when a fixed unlock word reaches private address 0x00, a manual calibration control word at 0x22 that drives the calibration outputs, and a read-only view at 0x26 of the code reported by the delay line. A three-state sequencer controls each access. It has the states `SQ_IDLE`, `SQ_ISSUE` and `SQ_DONE`, with these transitions: start accepted (IDLE→ISSUE), access performed (ISSUE→DONE) and release (DONE→IDLE). Because the sequencer acts only in `SQ_IDLE`, every access takes the same fixed two busy cycles.

Top module: `cal_bank_bridge`

## Requirements
- R1: After reset, busy is 0, the read-data register reads 0, the command register reads 0, cal_manual is 0, cal_trim is 0 and the bank is write-protected (a read of private address 0x00 returns 0).
- R2: The command register (host_addr 0) keeps the private address in bits 5:0 and the direction in bit 8, where 1 means read and 0 means write. Reading it back returns zero in every other bit.
- R3: An access starts only when a host write to the start register (host_addr 2) changes bit 0 from 0 to 1. Writing 1 when the bit is already 1 starts nothing.
- R4: busy rises in the cycle after the start edge and stays high for exactly two cycles. A read result is in the read-data register (host_addr 3), and a write has taken effect, by the time busy falls.
- R5: A start edge that arrives while busy is high is ignored. busy still falls on schedule.
- R6: Writing 0xA5000000 to private address 0x00 opens the bank. While the bank is open, a read of 0x00 returns 1 in bit 0. While it is protected, that read returns 0.
- R7: While the bank is protected, writes to any private address other than 0x00 have no effect.
- R8: Writing any value other than 0xA5000000 to private address 0x00 returns the bank to the protected state.
- R9: Private address 0x22 stores the manual-mode enable in bit 7 and the 5-bit calibration value in bits 4:0. These drive cal_manual and cal_trim, and a read returns only those bits. Writing 0 to 0x22 returns the bank to automatic calibration (cal_manual = 0).
- R10: Private address 0x26 returns auto_code in bits 4:0 and zero above them. Writes to 0x26 have no effect.
- R11: Reads of unimplemented private addresses return 0. The read-data register keeps its value through write accesses and changes only when a read access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select: 0 command, 1 write data, 2 start, 3 read data |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Value of the selected host register (combinational) |
| busy | output | 1 | A private access is in progress |
| auto_code | input | 5 | Calibration code reported by the delay line |
| cal_manual | output | 1 | Manual calibration enable |
| cal_trim | output | 5 | Manual calibration value |

## Verification
The hardest case to reach is a second start edge that lands inside the two-cycle busy window. Software normally clears the start bit before it raises it again, and that clear also has to fall inside the window. The bench reaches this case with back-to-back single-cycle host writes of 1, 0 and 1. The third write meets the sequencer in `SQ_DONE`, and the bench then confirms that busy drops on schedule. The write-protect gate is exercised through an ordered vector sequence that locks, unlocks and relocks the bank, and reads back after every step.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

    localparam int PRIV_AW = 6;
    localparam int WORD_W  = 32;
    localparam int HOST_AW = 2;

    typedef enum logic [HOST_AW-1:0] {
        HR_CMD   = 2'd0,
        HR_WDATA = 2'd1,
        HR_START = 2'd2,
        HR_RDATA = 2'd3
    } host_reg_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DONE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic               wr;
        logic [PRIV_AW-1:0] addr;
        logic [WORD_W-1:0]  data;
    } priv_access_t;

endpackage

// File: rtl/cbb_host_regs.sv
module cbb_host_regs
    import cbb_pkg::*;
#(
    parameter int DIR_BIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    input  logic               rd_capture,
    input  logic [WORD_W-1:0]  rd_value,
    output logic               start_rise,
    output logic               start_q,
    output logic [PRIV_AW-1:0] cmd_addr,
    output logic               cmd_rd,
    output logic [WORD_W-1:0]  wdata_q,
    output logic [WORD_W-1:0]  rdata_q
);

    logic wr_cmd;
    logic wr_wdata;
    logic wr_start;

    always_comb begin
        wr_cmd   = host_wr && (host_addr == HR_CMD);
        wr_wdata = host_wr && (host_addr == HR_WDATA);
        wr_start = host_wr && (host_addr == HR_START);
    end

    // edge only: the bit must go from 0 to 1 in this write
    assign start_rise = wr_start && host_wdata[0] && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_addr <= '0;
            cmd_rd   <= 1'b0;
        end else if (wr_cmd) begin
            cmd_addr <= host_wdata[PRIV_AW-1:0];
            cmd_rd   <= host_wdata[DIR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (wr_wdata) begin
            wdata_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else if (wr_start) begin
            start_q <= host_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_capture) begin
            rdata_q <= rd_value;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            HR_CMD: begin
                host_rdata[PRIV_AW-1:0] = cmd_addr;
                host_rdata[DIR_BIT]     = cmd_rd;
            end
            HR_WDATA: host_rdata    = wdata_q;
            HR_START: host_rdata[0] = start_q;
            HR_RDATA: host_rdata    = rdata_q;
            default:  host_rdata    = '0;
        endcase
    end

endmodule

// File: rtl/cbb_seq.sv
module cbb_seq
    import cbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_rise,
    input  logic               cmd_rd,
    input  logic [PRIV_AW-1:0] cmd_addr,
    input  logic [WORD_W-1:0]  wdata_q,
    output logic               busy,
    output logic               acc_en,
    output priv_access_t       acc,
    output logic               rd_capture
);

    seq_state_e   state_q;
    seq_state_e   state_d;
    priv_access_t acc_q;
    logic         accept;

    assign accept = (state_q == SQ_IDLE) && start_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // snapshot of the command at the accepted start edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q.wr   <= !cmd_rd;
            acc_q.addr <= cmd_addr;
            acc_q.data <= wdata_q;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (start_rise) state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = SQ_DONE;
            SQ_DONE:  state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        acc_en     = 1'b0;
        rd_capture = 1'b0;
        unique case (state_q)
            SQ_IDLE:  ;
            SQ_ISSUE: begin
                busy       = 1'b1;
                acc_en     = 1'b1;
                rd_capture = !acc_q.wr;
            end
            SQ_DONE:  busy = 1'b1;
            default:  ;
        endcase
    end

    assign acc = acc_q;

endmodule

// File: rtl/cbb_priv_bank.sv
module cbb_priv_bank
    import cbb_pkg::*;
#(
    parameter logic [WORD_W-1:0]  UNLOCK_KEY = 32'hA500_0000,
    parameter logic [PRIV_AW-1:0] KEY_ADDR   = 6'h00,
    parameter logic [PRIV_AW-1:0] CTRL_ADDR  = 6'h22,
    parameter logic [PRIV_AW-1:0] CODE_ADDR  = 6'h26,
    parameter int                 MANUAL_BIT = 7,
    parameter int                 CODE_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  priv_access_t       acc,
    input  logic [CODE_W-1:0]  auto_code,
    output logic [WORD_W-1:0]  rd_value,
    output logic               bank_open,
    output logic               cal_manual,
    output logic [CODE_W-1:0]  cal_trim
);

    logic do_write;
    logic key_hit;
    logic ctrl_hit;

    always_comb begin
        do_write = acc_en && acc.wr;
        key_hit  = do_write && (acc.addr == KEY_ADDR);
        ctrl_hit = do_write && (acc.addr == CTRL_ADDR) && bank_open;
    end

    // write-protect gate: any write to the key slot re-evaluates it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_open <= 1'b0;
        end else if (key_hit) begin
            bank_open <= (acc.data == UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_manual <= 1'b0;
            cal_trim   <= '0;
        end else if (ctrl_hit) begin
            cal_manual <= acc.data[MANUAL_BIT];
            cal_trim   <= acc.data[CODE_W-1:0];
        end
    end

    always_comb begin
        rd_value = '0;
        if (acc.addr == KEY_ADDR) begin
            rd_value[0] = bank_open;
        end else if (acc.addr == CTRL_ADDR) begin
            rd_value[MANUAL_BIT]   = cal_manual;
            rd_value[CODE_W-1:0]   = cal_trim;
        end else if (acc.addr == CODE_ADDR) begin
            rd_value[CODE_W-1:0]   = auto_code;
        end
    end

endmodule

// File: rtl/cal_bank_bridge.sv
module cal_bank_bridge
    import cbb_pkg::*;
#(
    parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'hA500_0000,
    parameter int                CODE_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [WORD_W-1:0]  host_rdata,
    output logic               busy,
    input  logic [CODE_W-1:0]  auto_code,
    output logic               cal_manual,
    output logic [CODE_W-1:0]  cal_trim
);

    logic               start_rise;
    logic               start_q;
    logic [PRIV_AW-1:0] cmd_addr;
    logic               cmd_rd;
    logic [WORD_W-1:0]  wdata_q;
    logic [WORD_W-1:0]  rdata_q;
    logic               rd_capture;
    logic [WORD_W-1:0]  rd_value;
    logic               acc_en;
    priv_access_t       acc;
    logic               bank_open;

    cbb_host_regs u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_capture (rd_capture),
        .rd_value   (rd_value),
        .start_rise (start_rise),
        .start_q    (start_q),
        .cmd_addr   (cmd_addr),
        .cmd_rd     (cmd_rd),
        .wdata_q    (wdata_q),
        .rdata_q    (rdata_q)
    );

    cbb_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rise (start_rise),
        .cmd_rd     (cmd_rd),
        .cmd_addr   (cmd_addr),
        .wdata_q    (wdata_q),
        .busy       (busy),
        .acc_en     (acc_en),
        .acc        (acc),
        .rd_capture (rd_capture)
    );

    cbb_priv_bank #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .CODE_W     (CODE_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc        (acc),
        .auto_code  (auto_code),
        .rd_value   (rd_value),
        .bank_open  (bank_open),
        .cal_manual (cal_manual),
        .cal_trim   (cal_trim)
    );

endmodule

// File: rtl/cbb_checker.sv
module cbb_checker #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              host_wr,
    input logic [1:0]        host_addr,
    input logic [31:0]       host_wdata,
    input logic              start_q,
    input logic [31:0]       rdata_q,
    input logic              bank_open,
    input logic              cal_manual,
    input logic [CODE_W-1:0] cal_trim
);

    // R3: busy only rises after a 0-to-1 write of the start bit
    a_r3_edge_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_wr && host_addr == 2'd2 && host_wdata[0] && !start_q));

    // R4 / R5: exactly two busy cycles, never extended
    a_r4_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R11: read data only moves during an access
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(rdata_q));

    // R7 / R9: calibration outputs only change through an access on an open bank
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_open || !busy) |=> $stable(cal_manual) && $stable(cal_trim));

    // R6 / R8: gate state changes only during an access
    a_r6_gate_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(bank_open));

endmodule

bind cal_bank_bridge cbb_checker #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .start_q    (start_q),
    .rdata_q    (rdata_q),
    .bank_open  (bank_open),
    .cal_manual (cal_manual),
    .cal_trim   (cal_trim)
);

// File: tb/cal_bank_bridge_bench.sv
module cal_bank_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy;
    logic [4:0]  auto_code = 5'h16;
    logic        cal_manual;
    logic [4:0]  cal_trim;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    cal_bank_bridge u_cal_bank_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .auto_code  (auto_code),
        .cal_manual (cal_manual),
        .cal_trim   (cal_trim)
    );

    // {is_read, private address, write data, expected read data}
    typedef struct packed {
        logic        rd;
        logic [5:0]  a;
        logic [31:0] d;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'h00, 32'h0,          32'h0},   // R1 R6 protected after reset
        '{1'b0, 6'h22, 32'h0000_0085,  32'h0},   // R7 write while locked
        '{1'b1, 6'h22, 32'h0,          32'h0},   // R7 no effect
        '{1'b0, 6'h00, 32'hA500_0000,  32'h0},   // R6 unlock
        '{1'b1, 6'h00, 32'h0,          32'h1},   // R6 open
        '{1'b0, 6'h22, 32'hFFFF_FF93,  32'h0},   // R9 manual write
        '{1'b1, 6'h22, 32'h0,          32'h93},  // R9 only bit 7 and 4:0
        '{1'b1, 6'h26, 32'h0,          32'h16},  // R10 auto code
        '{1'b0, 6'h26, 32'h0000_001F,  32'h0},   // R10 write ignored
        '{1'b1, 6'h26, 32'h0,          32'h16},  // R10
        '{1'b1, 6'h15, 32'h0,          32'h0},   // R11 unimplemented
        '{1'b0, 6'h00, 32'h1234_5678,  32'h0},   // R8 relock
        '{1'b1, 6'h00, 32'h0,          32'h0},   // R8
        '{1'b0, 6'h22, 32'h0,          32'h0},   // R7 ignored after relock
        '{1'b1, 6'h22, 32'h0,          32'h93},  // R7 value kept
        '{1'b1, 6'h3F, 32'h0,          32'h0}    // R11 top address
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        host_wr = 1'b1;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [1:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic access(input logic rd, input logic [5:0] a, input logic [31:0] d);
        hw(2'd0, {23'd0, rd, 2'd0, a});
        hw(2'd1, d);
        hw(2'd2, 32'd1);
        hw(2'd2, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] last_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        hr(2'd3, v); check("R1 rdata", v, 32'd0);
        hr(2'd0, v); check("R1 cmd", v, 32'd0);
        check("R1 cal_manual", {31'd0, cal_manual}, 32'd0);
        check("R1 cal_trim", {27'd0, cal_trim}, 32'd0);

        // R2 command layout
        hw(2'd0, 32'hFFFF_FFFF);
        hr(2'd0, v); check("R2 cmd fields", v, 32'h0000_013F);
        hw(2'd0, 32'h0000_0026 | 32'h100);
        hr(2'd0, v); check("R2 cmd read 0x26", v, 32'h0000_0126);

        // R4 busy timing, R5 edge during busy, R3 no edge when already 1
        hw(2'd2, 32'd1);
        check("R4 busy cycle 1", {31'd0, busy}, 32'd1);
        hw(2'd2, 32'd0);
        check("R4 busy cycle 2", {31'd0, busy}, 32'd1);
        hw(2'd2, 32'd1);
        check("R5 busy ends despite edge", {31'd0, busy}, 32'd0);
        hr(2'd3, v); check("R4 result at busy fall", v, 32'h16);
        hw(2'd2, 32'd1);
        check("R3 no start without edge", {31'd0, busy}, 32'd0);
        hw(2'd2, 32'd0);
        check("R3 still idle", {31'd0, busy}, 32'd0);
        last_rd = 32'h16;

        // reset again so the table starts from the protected state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        last_rd = 32'h0;

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].rd, VEC[i].a, VEC[i].d);
            hr(2'd3, v);
            if (VEC[i].rd) begin
                check($sformatf("vector %0d read (R6-R11 table)", i), v, VEC[i].exp);
                last_rd = VEC[i].exp;
            end else begin
                check($sformatf("vector %0d R11 rdata held", i), v, last_rd);
            end
        end

        // R9 outputs follow the control word, and 0 returns to automatic
        check("R9 manual after relock", {31'd0, cal_manual}, 32'd1);
        check("R9 trim after relock", {27'd0, cal_trim}, 32'h13);
        access(1'b0, 6'h00, 32'hA500_0000);
        access(1'b0, 6'h22, 32'h0000_009F);
        check("R9 manual set", {31'd0, cal_manual}, 32'd1);
        check("R9 trim set", {27'd0, cal_trim}, 32'h1F);
        access(1'b0, 6'h22, 32'h0);
        check("R9 automatic", {31'd0, cal_manual}, 32'd0);
        check("R9 trim cleared", {27'd0, cal_trim}, 32'd0);

        // R10 follows a changed auto code
        auto_code = 5'h09;
        access(1'b1, 6'h26, 32'h0);
        hr(2'd3, v); check("R10 new code", v, 32'h09);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule